// File: doc/BRIEF.md
# Strobe-Handshake Register Port

This block is the processor-facing register port of a byte-wide serial bus controller. A host reaches it over an asynchronous bus: a 24-bit address, active-low address and data strobes, a read/write line, an 8-bit bidirectional data bus, and an active-low acknowledge driven back by the block. Every access uses a fully interlocked four-phase handshake. The host lowers both strobes. The block answers by pulling the acknowledge low. The host then raises the strobes, and the block lets the acknowledge go.

The upper sixteen address bits must match a base value before the block responds. The low byte then selects one of four registers: the device's own bus address, a control byte, a read-only status byte and a data byte. The control, own-address and transmit values leave the block as plain outputs. Received data, engine status flags and an interrupt-set event come in from the serial engine. Before use, the strobes pass through a two-flop synchronizer clocked by the block's clock.

Top module: `hbus_regport`

## Requirements
- R1: The block never acknowledges, drives nothing on the data bus, and changes no register when address bits 23..8 differ from the base value (default 0x0000).
- R2: Inside the base range, low byte 0x8D selects the own-address register, 0x91 control, 0x93 status and 0x95 data. Own-address and control read back the last value written to them.
- R3: ack_n goes low on the third rising clock edge after both strobes fall. It stays low while either strobe is low, and it returns high on the third rising edge after both strobes are high again.
- R4: During a decoded read, the selected register value is on the data bus while both strobes are low. At all other times the bus is left at high impedance.
- R5: An active-low rst_n clears the own-address, control, transmit and pending-interrupt state and sets ack_n high at once, without waiting for a clock edge.
- R6: A write to control appears on ctrl_o. For example, 0xC0 sets the two enable bits 7 and 6.
- R7: A write to data loads tx_byte_o and raises tx_load_o for exactly one cycle, in the same cycle in which ack_n first goes low.
- R8: A read of data returns rx_byte_i.
- R9: A status read returns {xfer_done_i, eng_flags_i[5:0], pending} with the pending-interrupt bit at bit 0. Writes to status change nothing.
- R10: A cycle with irq_set_i high sets the pending bit. A data read clears it, unless irq_set_i is high on the clearing edge; in that case the bit stays set.
- R11: An access to any other low byte inside the base range is still acknowledged. A read returns 0x00, and a write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 24 | Host address |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| ack_n | output | 1 | Access acknowledge, active low |
| data_io | inout | 8 | Bidirectional host data bus |
| own_addr_o | output | 8 | Device address held for the engine |
| ctrl_o | output | 8 | Control byte |
| tx_byte_o | output | 8 | Byte to transmit |
| tx_load_o | output | 1 | One-cycle pulse when tx_byte_o is written |
| rx_byte_i | input | 8 | Last byte received by the engine |
| xfer_done_i | input | 1 | Transfer-complete flag from the engine |
| eng_flags_i | input | 6 | Further engine status flags |
| irq_set_i | input | 1 | Sets the pending-interrupt bit |

## Verification
Register writes, tx_load_o and the fall of ack_n all land on the third rising edge after the strobes drop: two edges in the synchronizer and one in the state register. The bench drives the strobes on falling edges and counts rising edges until it first sees ack_n low at a falling edge. It reads the data bus, tx_load_o and the register outputs at that same sample point. The release of ack_n is counted the same way from the rise of the strobes. A bus with a wrong base is given twelve cycles before the bench records that no acknowledge came.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  // Which register an access targets
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OWN,
    SEL_CTRL,
    SEL_STAT,
    SEL_DATA
  } sel_e;

  typedef enum logic {
    HS_IDLE,
    HS_ACK
  } hs_state_e;

  // Map the low address byte to a register select
  function automatic sel_e decode_offset(
    input logic [7:0] off,
    input logic [7:0] off_own,
    input logic [7:0] off_ctrl,
    input logic [7:0] off_stat,
    input logic [7:0] off_data
  );
    if (off == off_own)       return SEL_OWN;
    else if (off == off_ctrl) return SEL_CTRL;
    else if (off == off_stat) return SEL_STAT;
    else if (off == off_data) return SEL_DATA;
    else                      return SEL_NONE;
  endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hbus_handshake.sv
module hbus_handshake
  import hbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic as_s,
  input  logic ds_s,
  input  logic hit,
  output logic ack_n,
  output logic access_ev
);
  hs_state_e st;
  logic      strobes_low;
  logic      strobes_high;

  assign strobes_low  = !as_s && !ds_s;
  assign strobes_high = as_s && ds_s;
  // One event per access: only taken from idle
  assign access_ev    = (st == HS_IDLE) && strobes_low && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= HS_IDLE;
      ack_n <= 1'b1;
    end else begin
      case (st)
        HS_IDLE: if (access_ev) begin
          st    <= HS_ACK;
          ack_n <= 1'b0;
        end
        HS_ACK: if (strobes_high) begin
          st    <= HS_IDLE;
          ack_n <= 1'b1;
        end
        default: begin
          st    <= HS_IDLE;
          ack_n <= 1'b1;
        end
      endcase
    end
  end

  // R3: interlock holds acknowledge until both strobes are back high
  p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !strobes_high) |=> !ack_n);
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && strobes_high) |=> ack_n);
  p_ack_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    access_ev |=> !ack_n);
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile
  import hbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access_ev,
  input  logic              is_read,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              xfer_done,
  input  logic [DATA_W-3:0] flags,
  input  logic              irq_set,
  output logic [DATA_W-1:0] own_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] tx_q,
  output logic              tx_load,
  output logic [DATA_W-1:0] rdata
);
  logic irq_pend;
  logic wr_ev;
  logic data_rd_ev;

  // Status layout: done at the top, pending at bit 0
  function automatic logic [DATA_W-1:0] pack_status(
    input logic              done,
    input logic [DATA_W-3:0] f,
    input logic              pend
  );
    return {done, f, pend};
  endfunction

  assign wr_ev      = access_ev && !is_read;
  assign data_rd_ev = access_ev && is_read && (sel == SEL_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= '0;
      ctrl_q  <= '0;
      tx_q    <= '0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= wr_ev && (sel == SEL_DATA);
      if (wr_ev) begin
        case (sel)
          SEL_OWN:  own_q  <= wdata;
          SEL_CTRL: ctrl_q <= wdata;
          SEL_DATA: tx_q   <= wdata;
          default:  ;
        endcase
      end
    end
  end

  // Set has priority so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq_pend <= 1'b0;
    else if (irq_set)    irq_pend <= 1'b1;
    else if (data_rd_ev) irq_pend <= 1'b0;
  end

  always_comb begin
    case (sel)
      SEL_OWN:  rdata = own_q;
      SEL_CTRL: rdata = ctrl_q;
      SEL_STAT: rdata = pack_status(xfer_done, flags, irq_pend);
      SEL_DATA: rdata = rx_byte;
      default:  rdata = '0;
    endcase
  end

  // R7: the load strobe is a single-cycle pulse
  p_load_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);
  // R10: clear on data read, set on event
  p_rdclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_ev && !irq_set) |=> !irq_pend);
  p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq_pend);
  // R6: control only moves on an access
  p_ctrl_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !access_ev |=> $stable(ctrl_q));
endmodule

// File: rtl/hbus_regport.sv
module hbus_regport
  import hbus_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          DATA_W   = 8,
  parameter int          OFF_W    = 8,
  parameter logic [ADDR_W-OFF_W-1:0] BASE = '0,
  parameter logic [OFF_W-1:0] OFF_OWN  = 8'h8D,
  parameter logic [OFF_W-1:0] OFF_CTRL = 8'h91,
  parameter logic [OFF_W-1:0] OFF_STAT = 8'h93,
  parameter logic [OFF_W-1:0] OFF_DATA = 8'h95
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                as_n,
  input  logic                ds_n,
  input  logic                rd_wr,
  output logic                ack_n,
  inout  wire  [DATA_W-1:0]   data_io,
  output logic [DATA_W-1:0]   own_addr_o,
  output logic [DATA_W-1:0]   ctrl_o,
  output logic [DATA_W-1:0]   tx_byte_o,
  output logic                tx_load_o,
  input  logic [DATA_W-1:0]   rx_byte_i,
  input  logic                xfer_done_i,
  input  logic [DATA_W-3:0]   eng_flags_i,
  input  logic                irq_set_i
);
  localparam int SYNC_W = 2;

  logic              base_hit;
  sel_e              sel;
  logic [SYNC_W-1:0] strb_s;
  logic              access_ev;
  logic              drive_en;
  logic [DATA_W-1:0] rdata;

  assign base_hit = (bus_addr[ADDR_W-1:OFF_W] == BASE);
  assign sel      = decode_offset(bus_addr[OFF_W-1:0], OFF_OWN, OFF_CTRL,
                                  OFF_STAT, OFF_DATA);

  hbus_sync #(.W(SYNC_W), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({as_n, ds_n}),
    .q     (strb_s)
  );

  hbus_handshake u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .as_s      (strb_s[1]),
    .ds_s      (strb_s[0]),
    .hit       (base_hit),
    .ack_n     (ack_n),
    .access_ev (access_ev)
  );

  hbus_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .access_ev (access_ev),
    .is_read   (rd_wr),
    .sel       (sel),
    .wdata     (data_io),
    .rx_byte   (rx_byte_i),
    .xfer_done (xfer_done_i),
    .flags     (eng_flags_i),
    .irq_set   (irq_set_i),
    .own_q     (own_addr_o),
    .ctrl_q    (ctrl_o),
    .tx_q      (tx_byte_o),
    .tx_load   (tx_load_o),
    .rdata     (rdata)
  );

  // R4: drive only for a decoded read with both strobes low
  assign drive_en = !as_n && !ds_n && rd_wr && base_hit;
  assign data_io  = drive_en ? rdata : 'z;

  // R1: no acknowledge can start outside the base range
  p_no_ack_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_n && !base_hit) |=> ack_n);
  // R7: load pulse coincides with acknowledge
  p_load_with_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_o |-> !ack_n);
endmodule

// File: tb/hbus_regport_tb.sv
module hbus_regport_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        as_n = 1'b1, ds_n = 1'b1, rd_wr = 1'b1;
  logic        ack_n;
  logic [7:0]  drv_val = '0;
  logic        drv_en = 1'b0;
  wire  [7:0]  bus;
  logic [7:0]  own_addr_o, ctrl_o, tx_byte_o;
  logic        tx_load_o;
  logic [7:0]  rx_byte_i = '0;
  logic        xfer_done_i = 1'b0;
  logic [5:0]  eng_flags_i = '0;
  logic        irq_set_i = 1'b0;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [7:0] m_own = 0, m_ctrl = 0, m_tx = 0;
  logic       m_pend = 0;

  assign bus = drv_en ? drv_val : 8'hzz;

  always #2 clk = ~clk;

  hbus_regport u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .as_n(as_n), .ds_n(ds_n),
    .rd_wr(rd_wr), .ack_n(ack_n), .data_io(bus), .own_addr_o(own_addr_o),
    .ctrl_o(ctrl_o), .tx_byte_o(tx_byte_o), .tx_load_o(tx_load_o),
    .rx_byte_i(rx_byte_i), .xfer_done_i(xfer_done_i),
    .eng_flags_i(eng_flags_i), .irq_set_i(irq_set_i)
  );

  function automatic logic [7:0] exp_status(input logic d, input logic [5:0] f,
                                            input logic p);
    return (8'(d) << 7) | (8'(f) << 1) | 8'(p);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One four-phase access; latencies counted in rising edges
  task automatic access(input logic [23:0] a, input logic rd, input logic [7:0] wd,
                        output logic [7:0] rv, output logic acked,
                        output int lat_f, output int lat_r, output logic load_seen);
    @(negedge clk);
    bus_addr = a; rd_wr = rd; drv_val = wd; drv_en = !rd;
    as_n = 1'b0; ds_n = 1'b0;
    lat_f = 0; lat_r = 0; acked = 1'b0; rv = '0; load_seen = 1'b0;
    while (lat_f < 12) begin
      @(posedge clk); lat_f++;
      @(negedge clk);
      if (!ack_n) begin acked = 1'b1; break; end
    end
    rv = bus;
    load_seen = tx_load_o;
    as_n = 1'b1; ds_n = 1'b1; drv_en = 1'b0;
    if (acked) begin
      while (lat_r < 12) begin
        @(posedge clk); lat_r++;
        @(negedge clk);
        if (ack_n) break;
      end
    end else begin
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_set_i = 1'b1;
    @(negedge clk); irq_set_i = 1'b0;
    m_pend = 1'b1;
  endtask

  // shorthand wrappers
  logic [7:0] rv; logic ak, ld; int lf, lr;

  task automatic wr(input logic [7:0] off, input logic [7:0] d);
    access({16'h0000, off}, 1'b0, d, rv, ak, lf, lr, ld);
  endtask
  task automatic rdr(input logic [7:0] off);
    access({16'h0000, off}, 1'b1, 8'h00, rv, ak, lf, lr, ld);
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    // R5: reset state
    chk("R5 ack_n", ack_n, 1);
    chk("R5 ctrl", ctrl_o, 0);
    chk("R5 own", own_addr_o, 0);
    chk("R5 tx", tx_byte_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R3: own address write and readback, latency
    wr(8'h8D, 8'h0E);
    chk("R3 fall latency", lf, 3);
    chk("R3 release latency", lr, 3);
    chk("R2 own out", own_addr_o, 8'h0E); m_own = 8'h0E;
    rdr(8'h8D);
    chk("R2 own readback", rv, 8'h0E);
    chk("R4 read acked", ak, 1);

    // R6: control enable bits
    wr(8'h91, 8'hC0); m_ctrl = 8'hC0;
    chk("R6 ctrl", ctrl_o, 8'hC0);
    rdr(8'h91);
    chk("R2 ctrl readback", rv, 8'hC0);

    // R7: data write
    wr(8'h95, 8'hDE); m_tx = 8'hDE;
    chk("R7 tx byte", tx_byte_o, 8'hDE);
    chk("R7 load with ack", ld, 1);
    chk("R7 load one cycle", tx_load_o, 0);

    // R8: data read
    rx_byte_i = 8'hA5;
    rdr(8'h95);
    chk("R8 rx", rv, 8'hA5);

    // R9: status read and ignored write
    xfer_done_i = 1'b1; eng_flags_i = 6'h2B;
    rdr(8'h93);
    chk("R9 status", rv, exp_status(1'b1, 6'h2B, 1'b0));
    wr(8'h93, 8'hFF);
    rdr(8'h93);
    chk("R9 status write ignored", rv, exp_status(1'b1, 6'h2B, 1'b0));
    chk("R9 ctrl untouched", ctrl_o, m_ctrl);

    // R10: pending set, clear by data read, set wins
    pulse_irq();
    rdr(8'h93);
    chk("R10 pend set", rv[0], 1);
    rdr(8'h95);
    m_pend = 1'b0;
    rdr(8'h93);
    chk("R10 pend cleared", rv[0], 0);
    pulse_irq();
    irq_set_i = 1'b1;
    rdr(8'h95);
    irq_set_i = 1'b0;
    rdr(8'h93);
    chk("R10 set wins over clear", rv[0], 1);

    // R11: undecoded offset
    rdr(8'h90);
    chk("R11 undecoded acked", ak, 1);
    chk("R11 undecoded reads zero", rv, 0);
    wr(8'h90, 8'h55);
    chk("R11 undecoded ack on write", ak, 1);
    chk("R11 own kept", own_addr_o, m_own);
    chk("R11 ctrl kept", ctrl_o, m_ctrl);
    chk("R11 tx kept", tx_byte_o, m_tx);

    // R1: wrong base
    access(24'h010091, 1'b0, 8'h11, rv, ak, lf, lr, ld);
    chk("R1 no ack", ak, 0);
    chk("R1 ctrl kept", ctrl_o, m_ctrl);

    // random mix
    for (int i = 0; i < 80; i++) begin
      int kind;
      logic [7:0] off, wd;
      logic [15:0] hi;
      logic rd, exp_ack;
      logic [7:0] exp_rv;
      kind = $urandom % 6;
      rd = $urandom % 2;
      wd = 8'($urandom);
      hi = 16'h0000;
      rx_byte_i = 8'($urandom);
      eng_flags_i = 6'($urandom);
      xfer_done_i = 1'($urandom);
      if ($urandom % 5 == 0) pulse_irq();
      case (kind)
        0: off = 8'h8D;
        1: off = 8'h91;
        2: off = 8'h93;
        3: off = 8'h95;
        4: begin
          off = 8'($urandom);
          if (off == 8'h8D || off == 8'h91 || off == 8'h93 || off == 8'h95)
            off = off ^ 8'h01;
        end
        default: begin
          off = 8'h91;
          hi = 16'(1 + ($urandom % 65535));
        end
      endcase
      exp_ack = (hi == 16'h0000);
      exp_rv = 8'h00;
      if (exp_ack) begin
        case (off)
          8'h8D: if (rd) exp_rv = m_own; else m_own = wd;
          8'h91: if (rd) exp_rv = m_ctrl; else m_ctrl = wd;
          8'h93: if (rd) exp_rv = exp_status(xfer_done_i, eng_flags_i, m_pend);
          8'h95: if (rd) exp_rv = rx_byte_i; else m_tx = wd;
          default: ;
        endcase
      end
      access({hi, off}, rd, wd, rv, ak, lf, lr, ld);
      if (exp_ack && rd && off == 8'h95) m_pend = 1'b0;
      chk("R1 random ack", ak, exp_ack);
      if (exp_ack) begin
        chk("R3 random latency", lf, 3);
        chk("R3 random release", lr, 3);
        if (rd) chk("R4 random read", rv, exp_rv);
        chk("R7 random load", ld, (!rd && off == 8'h95));
      end
      chk("R2 random own", own_addr_o, m_own);
      chk("R6 random ctrl", ctrl_o, m_ctrl);
      chk("R11 random tx", tx_byte_o, m_tx);
    end

    // R5: asynchronous reset mid-run
    wr(8'h91, 8'h3C);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R5 async ctrl clear", ctrl_o, 0);
    chk("R5 async ack high", ack_n, 1);
    @(negedge clk); rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule